// File: doc/BRIEF.md
# Flash Instruction Cache with Stall-Only Allocation

This block sits between a processor's instruction fetch port and a slow flash array whose reads take a fixed two cycles. A direct-mapped store of 32-bit words, each holding two 16-bit instruction codes, answers a request in the same cycle when it hits. A one-word sequential prefetcher always reads the word after the one just delivered, so straight-line code paced at one word per two cycles never waits. The flash read for a request that misses both the store and the prefetch buffer is launched in the same cycle as the lookup, so a miss costs only the flash latency.

Three control inputs shape the behaviour. `cache_en` turns the store on. While it is low no lookup hits, every valid bit is cleared, and the prefetch buffer keeps working. `cache_lock` freezes the store for all entries at once: lookups still hit, but nothing is written. `miss_only` switches allocation from storing every word delivered by flash to storing only words whose fetch stalled because the requested address was not the predicted one. All three are expected low after reset. The store then comes up empty, unlocked and in standard allocation.

The fetch sequencer has four states. FS_IDLE means no flash read is in flight and the buffer is empty. FS_WAIT1 is the first latency cycle, in which no new read may start. FS_WAIT2 is the cycle the flash word arrives. FS_HELD means the arrived word is held in the buffer. The transitions are named as follows. ISSUE goes from FS_IDLE or FS_HELD to FS_WAIT1 when a read is launched. ADVANCE goes from FS_WAIT1 to FS_WAIT2. REISSUE goes from FS_WAIT2 to FS_WAIT1 when a new read is launched as the word arrives. PARK goes from FS_WAIT2 to FS_HELD when no read is launched.

Top module: `flash_icache`

## Requirements
- R1: While reset is asserted and just after it, with no request, `cpu_ready` and `flash_req` are low and the store is empty.
- R2: A request that hits neither the store nor the prefetch buffer raises `flash_req` in the same cycle, with `flash_addr` equal to the requested word address. `cpu_ready` then rises exactly two cycles later, and `cpu_rdata` carries the flash word at that address. `cpu_ready` is never high without `cpu_req`.
- R3: When the requested word address equals the buffered prefetch address, the word is returned in the request cycle with no wait. In that same cycle `flash_req` rises with `flash_addr` equal to the request plus one.
- R4: With `miss_only` low, every word delivered from flash or from the prefetch buffer is written to the store, including prefetched sequential words. A later non-sequential request to it returns in zero wait cycles with the same data.
- R5: With `miss_only` high, only words whose fetch stalled on a mispredicted address are written. A prefetched sequential word served without a stall is not stored, so a later non-sequential request for it waits two cycles.
- R6: With `cache_lock` high, no entry is written or replaced, and words stored earlier still hit.
- R7: With `cache_en` low, no request hits and sequential prefetch still delivers with zero waits. Lowering `cache_en` invalidates every entry, and nothing delivered while it is low is stored.
- R8: The store is direct-mapped on the low four bits of the word address. Two addresses with equal low bits evict each other.
- R9: Flash reads are spaced at least two cycles apart. A sequential request made one cycle after the previous word was delivered waits one cycle; one made two cycles after waits none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Store enable; low clears all entries |
| cache_lock | input | 1 | Global write freeze of the store |
| miss_only | input | 1 | Allocate only words that stalled on a misprediction |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | WADDR_W | Requested word address |
| cpu_ready | output | 1 | Word delivered this cycle |
| cpu_rdata | output | DATA_W | Delivered instruction word |
| flash_req | output | 1 | Start a flash read this cycle |
| flash_addr | output | WADDR_W | Word address of the flash read |
| flash_rdata | input | DATA_W | Flash word, valid two cycles after its request |

## Verification
On every cycle the checker enforces several rules. `cpu_ready` only answers a request. Flash reads never start on adjacent cycles. Any stalled request that has no read in flight launches one at once. A locked store receives no writes. A disabled store neither hits nor keeps a valid entry. In stall-only mode, a write happens only after a cycle in which the processor waited. Which words end up stored, the exact number of wait cycles, eviction between aliasing addresses, and the survival of old entries under the lock show only through the directed scenarios. Those scenarios replay address sequences and predict the wait counts from the allocation rules.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_WAIT1 = 2'd1,
        FS_WAIT2 = 2'd2,
        FS_HELD  = 2'd3
    } fetch_state_e;

endpackage

// File: rtl/icache_store.sv
module icache_store #(
    parameter int WADDR_W = 18,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [WADDR_W-1:0] look_addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               hit,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ENTRIES-1:0] valid_vec
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = WADDR_W - IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  word_q [ENTRIES];

    logic [IDX_W-1:0] slot;
    logic [TAG_W-1:0] key;

    assign slot = look_addr[IDX_W-1:0];
    assign key  = look_addr[WADDR_W-1:IDX_W];

    // valid bits: cleared by reset or while the store is off
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[slot] <= 1'b1;
        end
    end

    // tag and word arrays need no reset, guarded by valid bits
    always_ff @(posedge clk) begin
        if (wr_en && enable) begin
            tag_q[slot]  <= key;
            word_q[slot] <= wr_data;
        end
    end

    always_comb begin
        hit     = enable && valid_q[slot] && (tag_q[slot] == key);
        rd_data = word_q[slot];
    end

    assign valid_vec = valid_q;

endmodule

// File: rtl/icache_policy.sv
module icache_policy (
    input  logic cache_en,
    input  logic cache_lock,
    input  logic miss_only,
    input  logic deliver,
    input  logic stalled,
    output logic wr_en
);
    logic mode_ok;

    always_comb begin
        mode_ok = !miss_only || stalled;
        wr_en   = deliver && cache_en && !cache_lock && mode_ok;
    end

endmodule

// File: rtl/icache_fetch_fsm.sv
module icache_fetch_fsm
    import icache_pkg::*;
#(
    parameter int WADDR_W = 18,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [WADDR_W-1:0] cpu_addr,
    input  logic               store_hit,
    input  logic [DATA_W-1:0]  flash_rdata,
    output logic               buf_hit,
    output logic [DATA_W-1:0]  buf_data,
    output logic               buf_stalled,
    output logic               flash_req,
    output logic [WADDR_W-1:0] flash_addr
);
    fetch_state_e st_q, st_d;

    logic [WADDR_W-1:0] fl_addr_q;
    logic               fl_demand_q;
    logic [DATA_W-1:0]  hold_q;

    logic arriving, holding, can_issue, served;
    logic issue_dem, issue_pf;

    // next state: ISSUE, ADVANCE, REISSUE, PARK
    always_comb begin
        arriving  = (st_q == FS_WAIT2);
        holding   = (st_q == FS_HELD);
        can_issue = (st_q != FS_WAIT1);

        buf_hit   = cpu_req && !store_hit && (arriving || holding)
                    && (fl_addr_q == cpu_addr);
        buf_data  = arriving ? flash_rdata : hold_q;
        buf_stalled = fl_demand_q;

        served    = cpu_req && (store_hit || buf_hit);
        issue_dem = can_issue && cpu_req && !served;
        issue_pf  = can_issue && served;

        flash_req  = issue_dem || issue_pf;
        flash_addr = issue_dem ? cpu_addr : (cpu_addr + WADDR_W'(1));

        st_d = st_q;
        unique case (st_q)
            FS_IDLE:  if (flash_req) st_d = FS_WAIT1;
            FS_HELD:  if (flash_req) st_d = FS_WAIT1;
            FS_WAIT1: st_d = FS_WAIT2;
            FS_WAIT2: st_d = flash_req ? FS_WAIT1 : FS_HELD;
            default:  st_d = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // flight and buffer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_addr_q   <= '0;
            fl_demand_q <= 1'b0;
            hold_q      <= '0;
        end else begin
            if (flash_req) begin
                fl_addr_q   <= flash_addr;
                fl_demand_q <= issue_dem;
            end
            if (arriving && !flash_req) begin
                hold_q <= flash_rdata;
            end
        end
    end

endmodule

// File: rtl/flash_icache.sv
module flash_icache #(
    parameter int WADDR_W = 18,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_en,
    input  logic               cache_lock,
    input  logic               miss_only,
    input  logic               cpu_req,
    input  logic [WADDR_W-1:0] cpu_addr,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               flash_req,
    output logic [WADDR_W-1:0] flash_addr,
    input  logic [DATA_W-1:0]  flash_rdata
);
    logic               store_hit;
    logic [DATA_W-1:0]  store_data;
    logic [ENTRIES-1:0] valid_vec;
    logic               buf_hit;
    logic [DATA_W-1:0]  buf_data;
    logic               buf_stalled;
    logic               wr_en;
    logic               look_hit;

    assign look_hit = cpu_req && store_hit;

    icache_store #(
        .WADDR_W (WADDR_W),
        .DATA_W  (DATA_W),
        .ENTRIES (ENTRIES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cache_en),
        .look_addr (cpu_addr),
        .wr_en     (wr_en),
        .wr_data   (buf_data),
        .hit       (store_hit),
        .rd_data   (store_data),
        .valid_vec (valid_vec)
    );

    icache_fetch_fsm #(
        .WADDR_W (WADDR_W),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_addr    (cpu_addr),
        .store_hit   (look_hit),
        .flash_rdata (flash_rdata),
        .buf_hit     (buf_hit),
        .buf_data    (buf_data),
        .buf_stalled (buf_stalled),
        .flash_req   (flash_req),
        .flash_addr  (flash_addr)
    );

    icache_policy u_policy (
        .cache_en   (cache_en),
        .cache_lock (cache_lock),
        .miss_only  (miss_only),
        .deliver    (buf_hit),
        .stalled    (buf_stalled),
        .wr_en      (wr_en)
    );

    always_comb begin
        cpu_ready = look_hit || buf_hit;
        cpu_rdata = look_hit ? store_data : buf_data;
    end

endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cache_en,
    input logic               cache_lock,
    input logic               miss_only,
    input logic               cpu_req,
    input logic               cpu_ready,
    input logic               flash_req,
    input logic               store_hit,
    input logic               wr_en,
    input logic [ENTRIES-1:0] valid_vec
);

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req); // R2

    AST_STALL_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready && !$past(flash_req)) |-> flash_req); // R2

    AST_FLASH_PACE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |=> !flash_req); // R9

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cache_lock |-> !wr_en); // R6

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_en |-> !store_hit); // R7

    AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cache_en) |-> (valid_vec == '0)); // R7

    AST_STALL_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_only && wr_en) |-> $past(cpu_req && !cpu_ready)); // R5

endmodule

bind flash_icache icache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cache_en   (cache_en),
    .cache_lock (cache_lock),
    .miss_only  (miss_only),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .flash_req  (flash_req),
    .store_hit  (store_hit),
    .wr_en      (wr_en),
    .valid_vec  (valid_vec)
);

// File: tb/tb_flash_icache.sv
module tb_flash_icache;
    localparam int AW = 18;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cache_en = 1'b0;
    logic          cache_lock = 1'b0;
    logic          miss_only = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          flash_req;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic          fr0;
    logic [AW-1:0] fa0;

    always #4 clk = ~clk;   // 125 MHz

    flash_icache dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cache_en    (cache_en),
        .cache_lock  (cache_lock),
        .miss_only   (miss_only),
        .cpu_req     (cpu_req),
        .cpu_addr    (cpu_addr),
        .cpu_ready   (cpu_ready),
        .cpu_rdata   (cpu_rdata),
        .flash_req   (flash_req),
        .flash_addr  (flash_addr),
        .flash_rdata (flash_rdata)
    );

    // flash model: two-cycle fixed latency
    function automatic logic [DW-1:0] fword(input logic [AW-1:0] a);
        return {a[13:0], a} ^ 32'h5A5A_0000;
    endfunction

    logic [AW-1:0] st1, st2;
    always_ff @(posedge clk) begin
        st1 <= flash_addr;
        st2 <= st1;
    end
    assign flash_rdata = fword(st2);

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // caller stands at a negedge; returns at a negedge with cpu_req low
    task automatic fetch(input logic [AW-1:0] a, input int exp_w, input string tag);
        int w = 0;
        logic [DW-1:0] d;
        cpu_req  = 1'b1;
        cpu_addr = a;
        #2;
        fr0 = flash_req;
        fa0 = flash_addr;
        while (!cpu_ready && w < 20) begin
            @(negedge clk);
            w++;
            #2;
        end
        d = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        check(w == exp_w, tag, "wait cycles", w, exp_w);
        check(d == fword(a), tag, "data", d, fword(a));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #2;
        check(!cpu_ready && !flash_req, "R1", "outputs in reset",
              {cpu_ready, flash_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        #2;
        check(!cpu_ready && !flash_req, "R1", "outputs after reset",
              {cpu_ready, flash_req}, 0);
        @(negedge clk);
        cache_en = 1'b1;
        idle(2);
    endtask

    task automatic t_demand();
        fetch(18'h100, 2, "R1");         // empty store: full miss
        check(fr0 == 1'b1 && fa0 == 18'h100, "R2", "flash launched with lookup",
              {fr0, fa0}, {1'b1, 18'h100});
        idle(4);
    endtask

    task automatic t_sequential();
        fetch(18'h101, 0, "R3");
        check(fr0 == 1'b1 && fa0 == 18'h102, "R3", "next prefetch",
              {fr0, fa0}, {1'b1, 18'h102});
        idle(4);
    endtask

    task automatic t_standard();
        fetch(18'h100, 0, "R4");         // stored by demand
        idle(4);
        fetch(18'h305, 2, "R4");
        idle(4);
        fetch(18'h101, 0, "R4");         // stored from prefetch delivery
        idle(4);
        fetch(18'h305, 0, "R4");
        idle(4);
    endtask

    task automatic t_miss_only();
        miss_only = 1'b1;
        cache_en  = 1'b0;
        idle(2);
        cache_en  = 1'b1;
        idle(4);
        fetch(18'h200, 2, "R5");
        idle(4);
        fetch(18'h201, 0, "R5");         // via prefetch, not stored
        idle(4);
        fetch(18'h207, 2, "R5");
        idle(4);
        fetch(18'h201, 2, "R5");         // not stored earlier: stalls
        idle(4);
        fetch(18'h200, 0, "R5");         // stalled word kept
        idle(4);
        fetch(18'h20A, 2, "R5");
        idle(4);
        fetch(18'h201, 0, "R5");         // stored after its stall
        idle(4);
    endtask

    task automatic t_lock();
        miss_only  = 1'b0;
        cache_lock = 1'b1;
        idle(1);
        fetch(18'h400, 2, "R6");
        idle(4);
        fetch(18'h200, 0, "R6");         // not replaced by 0x400
        idle(4);
        fetch(18'h400, 2, "R6");         // never written
        idle(4);
        cache_lock = 1'b0;
    endtask

    task automatic t_disabled();
        cache_en = 1'b0;
        idle(2);
        fetch(18'h500, 2, "R7");
        idle(4);
        fetch(18'h501, 0, "R7");         // prefetch still serves
        idle(4);
        fetch(18'h200, 2, "R7");         // no hit while off
        idle(2);
        cache_en = 1'b1;
        idle(4);
        fetch(18'h207, 2, "R7");         // entries cleared
        idle(4);
        fetch(18'h500, 2, "R7");         // nothing stored while off
        idle(4);
    endtask

    task automatic t_conflict();
        fetch(18'h600, 2, "R8");
        idle(4);
        fetch(18'h500, 2, "R8");         // evicted by 0x600
        idle(4);
        fetch(18'h600, 2, "R8");         // evicted by 0x500
        idle(4);
    endtask

    task automatic t_pace();
        fetch(18'h710, 2, "R9");
        fetch(18'h711, 1, "R9");         // one cycle after delivery
        idle(1);
        fetch(18'h712, 0, "R9");         // two cycles after delivery
        check(fr0 == 1'b1 && fa0 == 18'h713, "R9", "prefetch follows",
              {fr0, fa0}, {1'b1, 18'h713});
        idle(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_demand();
        t_sequential();
        t_standard();
        t_miss_only();
        t_lock();
        t_disabled();
        t_conflict();
        t_pace();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule